// File: doc/BRIEF.md
# Audio Codec Reset Sequencer

This block orders the soft reset and power-down of a multi-channel audio converter's digital section. A control bit held in a register, `runBit`, asks for the converters to run (1) or to be held in power-down (0). The sequencer turns changes of that bit into a delayed internal reset, an ADC initialization window, zero-forcing enables for the ADC serial outputs and the DAC input path, and a set of zero-detect flag pins. All of its delays are measured in sample periods. It does not count master-clock cycles.

The sample period comes from the frame clock. That clock is synchronized into the master clock domain, and each rising edge gives a one-cycle strobe. Every delay counter moves only on that strobe. If the audio clocks stop while the converter is in reset, the sequence therefore freezes rather than running on. The block holds no control register of its own, so a soft reset leaves the register file untouched. Only the datapath enables change.

Entering reset and leaving it use different delays. Release is followed by a long ADC initialization window, and the zero-detect flags are released on their own later delay. Dropping the bit during initialization aborts the window and sends the sequencer back through the entry delay.

Top module: `codec_rst_seq`

## Requirements
- R1: While `rstN` is low, and right after it rises, `seqState` is 2'b00, `coreRstN` is 0, all `adcZero` bits and `dacZero` are 1, `adcInit` is 0 and all `zeroFlag` bits are 1.
- R2: In INIT or NORMAL with `runBit` at 0, the internal reset asserts (`coreRstN` goes to 0 and `seqState` to 2'b00) on the 5th frame strobe after `runBit` fell. If `runBit` returns to 1 before that strobe, the entry is cancelled and the count restarts from zero.
- R3: In RESET with `runBit` at 1, the sequencer leaves RESET on the 2nd frame strobe. While `runBit` is 0 it stays in RESET.
- R4: After release the sequencer is in INIT (`adcInit` = 1) for exactly 516 frame strobes. On the 516th strobe it moves to NORMAL. It never goes from RESET straight to NORMAL.
- R5: Every `adcZero` bit is 1 in RESET and INIT and 0 in NORMAL. `dacZero` is 1 exactly in RESET.
- R6: Every `zeroFlag` bit is 1 one clock after `runBit` is sampled at 0, whatever the state.
- R7: The `zeroFlag` bits return to 0 on the 7th frame strobe after `runBit` became 1, provided `runBit` stays 1 throughout.
- R8: `runBit` at 0 during INIT follows the R2 entry path. A later release starts a fresh 516-strobe INIT window.
- R9: `seqState` encodes RESET as 2'b00, INIT as 2'b01 and NORMAL as 2'b10. The value 2'b11 never appears.
- R10: A frame strobe is the rising edge of `frameClk` after synchronization. `seqState` and the flag release advance only on such strobes, so with `frameClk` stopped the state holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| frameClk | input | 1 | Frame clock, asynchronous to `clk` |
| runBit | input | 1 | Register control bit: 1 run, 0 power down |
| coreRstN | output | 1 | Internal converter reset, active low |
| adcInit | output | 1 | ADC initialization window active |
| adcZero | output | NUM_ADC (2) | Force each ADC serial data output to zero |
| dacZero | output | 1 | Force DAC input data to zero |
| zeroFlag | output | NUM_FLAGS (2) | Zero-detect flag pins |
| seqState | output | 2 | Sequencer state: 00 RESET, 01 INIT, 10 NORMAL |

## Verification
The assertions assume that `runBit` changes at most once per frame period and never in the few master-clock cycles around a synchronized frame edge. They also assume the frame clock is slow against `clk`, so each edge gives exactly one strobe. The stimulus meets both assumptions. It moves `frameClk` and `runBit` only on falling `clk` edges, keeps a 16-cycle frame, and changes `runBit` ten cycles after each frame rise. Random segments choose the bit level and how many frames it is held. A stretch with the frame clock stopped checks that nothing advances without strobes.

// File: rtl/codec_rst_seq_pkg.sv
`timescale 1ns/1ps
package codec_rst_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_RESET  = 2'b00,
    SEQ_INIT   = 2'b01,
    SEQ_NORMAL = 2'b10
  } seq_state_e;

  // control -> datapath: counter enables
  typedef struct packed {
    logic entryEn;
    logic releaseEn;
    logic initEn;
  } seq_cmd_t;

  // datapath -> control: terminal-count strobes
  typedef struct packed {
    logic entryDone;
    logic releaseDone;
    logic initDone;
  } seq_done_t;

endpackage

// File: rtl/codec_rst_seq_tick.sv
`timescale 1ns/1ps
module codec_rst_seq_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameClk,
  output logic frameTick
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], frameClk};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign frameTick = syncQ[SYNC_STAGES-1] & ~prevQ;
endmodule

// File: rtl/codec_rst_seq_cnt.sv
`timescale 1ns/1ps
module codec_rst_seq_cnt #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic tick,
  output logic done
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cntQ;

  assign done = en & tick & (cntQ == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= '0;
    else if (!en || done)    cntQ <= '0;
    else if (tick)           cntQ <= cntQ + 1'b1;
  end
endmodule

// File: rtl/codec_rst_seq_dp.sv
`timescale 1ns/1ps
module codec_rst_seq_dp
  import codec_rst_seq_pkg::*;
#(
  parameter int ENTRY_TICKS   = 5,
  parameter int RELEASE_TICKS = 2,
  parameter int INIT_TICKS    = 516,
  parameter int FLAG_TICKS    = 7,
  parameter int NUM_FLAGS     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 runBit,
  input  seq_cmd_t             cmd,
  output seq_done_t            done,
  output logic [NUM_FLAGS-1:0] flagsOut
);
  logic flagQ;
  logic flagDone;

  codec_rst_seq_cnt #(.LIMIT(ENTRY_TICKS)) u_entryCnt (
    .clk(clk), .rstN(rstN), .en(cmd.entryEn), .tick(tick), .done(done.entryDone));

  codec_rst_seq_cnt #(.LIMIT(RELEASE_TICKS)) u_releaseCnt (
    .clk(clk), .rstN(rstN), .en(cmd.releaseEn), .tick(tick), .done(done.releaseDone));

  codec_rst_seq_cnt #(.LIMIT(INIT_TICKS)) u_initCnt (
    .clk(clk), .rstN(rstN), .en(cmd.initEn), .tick(tick), .done(done.initDone));

  codec_rst_seq_cnt #(.LIMIT(FLAG_TICKS)) u_flagCnt (
    .clk(clk), .rstN(rstN), .en(runBit & flagQ), .tick(tick), .done(flagDone));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         flagQ <= 1'b1;
    else if (!runBit)  flagQ <= 1'b1;
    else if (flagDone) flagQ <= 1'b0;
  end

  assign flagsOut = {NUM_FLAGS{flagQ}};
endmodule

// File: rtl/codec_rst_seq_ctrl.sv
`timescale 1ns/1ps
module codec_rst_seq_ctrl
  import codec_rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runBit,
  input  seq_done_t  done,
  output seq_cmd_t   cmd,
  output seq_state_e state
);
  seq_state_e stateQ, stateD;

  always_comb begin
    cmd.entryEn   = (stateQ != SEQ_RESET) && !runBit;
    cmd.releaseEn = (stateQ == SEQ_RESET) && runBit;
    cmd.initEn    = (stateQ == SEQ_INIT);
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      SEQ_RESET:  if (done.releaseDone) stateD = SEQ_INIT;
      SEQ_INIT:   if (done.entryDone)   stateD = SEQ_RESET;
                  else if (done.initDone) stateD = SEQ_NORMAL;
      SEQ_NORMAL: if (done.entryDone)   stateD = SEQ_RESET;
      default:    stateD = SEQ_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SEQ_RESET;
    else       stateQ <= stateD;
  end

  assign state = stateQ;
endmodule

// File: rtl/codec_rst_seq.sv
`timescale 1ns/1ps
module codec_rst_seq
  import codec_rst_seq_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int ENTRY_TICKS   = 5,
  parameter int RELEASE_TICKS = 2,
  parameter int INIT_TICKS    = 516,
  parameter int FLAG_TICKS    = 7,
  parameter int NUM_FLAGS     = 2,
  parameter int NUM_ADC       = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameClk,
  input  logic                 runBit,
  output logic                 coreRstN,
  output logic                 adcInit,
  output logic [NUM_ADC-1:0]   adcZero,
  output logic                 dacZero,
  output logic [NUM_FLAGS-1:0] zeroFlag,
  output logic [1:0]           seqState
);
  logic       frameTick;
  seq_cmd_t   cmd;
  seq_done_t  done;
  seq_state_e state;

  codec_rst_seq_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rstN(rstN), .frameClk(frameClk), .frameTick(frameTick));

  codec_rst_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runBit(runBit), .done(done), .cmd(cmd), .state(state));

  codec_rst_seq_dp #(
    .ENTRY_TICKS(ENTRY_TICKS), .RELEASE_TICKS(RELEASE_TICKS),
    .INIT_TICKS(INIT_TICKS), .FLAG_TICKS(FLAG_TICKS), .NUM_FLAGS(NUM_FLAGS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick(frameTick), .runBit(runBit),
    .cmd(cmd), .done(done), .flagsOut(zeroFlag));

  assign seqState = state;
  assign coreRstN = (state != SEQ_RESET);
  assign adcInit  = (state == SEQ_INIT);
  assign dacZero  = (state == SEQ_RESET);

  for (genvar g = 0; g < NUM_ADC; g++) begin : g_adc
    assign adcZero[g] = (state != SEQ_NORMAL);
  end
endmodule

// File: rtl/codec_rst_seq_chk.sv
`timescale 1ns/1ps
module codec_rst_seq_chk #(
  parameter int NUM_FLAGS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 runBit,
  input logic                 frameTick,
  input logic [1:0]           seqState,
  input logic [NUM_FLAGS-1:0] zeroFlag
);
  // R9
  state_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqState != 2'b11);

  // R10
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(seqState) |-> $past(frameTick));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |=> &zeroFlag);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(zeroFlag[0]) |-> ($past(runBit) && $past(frameTick)));

  // R3
  hold_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 2'b00 && !runBit) |=> seqState == 2'b00);

  // R4
  no_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqState == 2'b00 |=> seqState != 2'b10);
endmodule

bind codec_rst_seq codec_rst_seq_chk #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
  .clk(clk), .rstN(rstN), .runBit(runBit), .frameTick(frameTick),
  .seqState(seqState), .zeroFlag(zeroFlag));

// File: tb/codec_rst_seq_bench.sv
`timescale 1ns/1ps
module codec_rst_seq_bench;
  localparam int NUM_FLAGS = 2;
  localparam int NUM_ADC   = 2;

  logic clk = 1'b0, rstN = 1'b0, frameClk = 1'b0, runBit = 1'b0;
  logic                 coreRstN, adcInit, dacZero;
  logic [NUM_ADC-1:0]   adcZero;
  logic [NUM_FLAGS-1:0] zeroFlag;
  logic [1:0]           seqState;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model, advanced once per frame edge
  logic [1:0] mState = 2'b00;
  int eCnt = 0, rCnt = 0, iCnt = 0, fCnt = 0;
  bit mFlag = 1;

  always #2.5 clk = ~clk;

  codec_rst_seq u_codec_rst_seq (
    .clk(clk), .rstN(rstN), .frameClk(frameClk), .runBit(runBit),
    .coreRstN(coreRstN), .adcInit(adcInit), .adcZero(adcZero), .dacZero(dacZero),
    .zeroFlag(zeroFlag), .seqState(seqState));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expAdc(input logic [1:0] s);
    return (s != 2'b10) ? ((1 << NUM_ADC) - 1) : 0;
  endfunction

  function automatic int expFlags(input bit f);
    return f ? ((1 << NUM_FLAGS) - 1) : 0;
  endfunction

  task automatic model_tick();
    bit r, entryOn, releaseOn, initOn, eDone, rDone, iDone;
    r = runBit;
    entryOn   = (mState != 2'b00) && !r;
    releaseOn = (mState == 2'b00) && r;
    initOn    = (mState == 2'b01);
    eDone = entryOn   && (eCnt == 4);
    rDone = releaseOn && (rCnt == 1);
    iDone = initOn    && (iCnt == 515);
    eCnt = (entryOn   && !eDone) ? eCnt + 1 : 0;
    rCnt = (releaseOn && !rDone) ? rCnt + 1 : 0;
    iCnt = (initOn    && !iDone) ? iCnt + 1 : 0;
    if (mState == 2'b00 && rDone)      mState = 2'b01;
    else if (mState != 2'b00 && eDone) mState = 2'b00;
    else if (mState == 2'b01 && iDone) mState = 2'b10;
    if (!r) begin
      mFlag = 1; fCnt = 0;
    end else if (mFlag) begin
      if (fCnt == 6) begin mFlag = 0; fCnt = 0; end
      else fCnt++;
    end
  endtask

  task automatic check_all();
    // R2 R3 R4 R8 R9: state sequence and encoding
    chk(seqState == mState, "R2/R3/R4/R8/R9 seqState", seqState, mState);
    chk(coreRstN == (mState != 2'b00), "R2 coreRstN", coreRstN, mState != 2'b00);
    chk(adcInit == (mState == 2'b01), "R4 adcInit", adcInit, mState == 2'b01);
    chk(adcZero == NUM_ADC'(expAdc(mState)), "R5 adcZero", adcZero, expAdc(mState));
    chk(dacZero == (mState == 2'b00), "R5 dacZero", dacZero, mState == 2'b00);
    chk(zeroFlag == NUM_FLAGS'(expFlags(mFlag)), "R7 zeroFlag", zeroFlag, expFlags(mFlag));
  endtask

  // one 16-cycle frame; runBit takes nextRun ten cycles after the frame rise
  task automatic frame(input bit nextRun);
    bit fell;
    @(negedge clk) frameClk = 1'b1;
    model_tick();
    repeat (6) @(negedge clk);
    check_all();
    repeat (2) @(negedge clk);
    frameClk = 1'b0;
    repeat (2) @(negedge clk);
    fell = runBit && !nextRun;
    runBit = nextRun;
    if (!nextRun) begin mFlag = 1; fCnt = 0; end
    repeat (2) @(negedge clk);
    if (fell) chk(zeroFlag == NUM_FLAGS'(expFlags(1)), "R6 zeroFlag set", zeroFlag, expFlags(1));
    repeat (3) @(negedge clk);
  endtask

  task automatic frames(input bit lvl, input int n);
    for (int i = 0; i < n; i++) frame(lvl);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0dec55));
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(seqState == 2'b00, "R1 seqState in reset", seqState, 0);
    chk(zeroFlag == NUM_FLAGS'(expFlags(1)), "R1 flags in reset", zeroFlag, expFlags(1));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(coreRstN == 1'b0, "R1 coreRstN", coreRstN, 0);
    chk(adcZero == NUM_ADC'(expAdc(2'b00)) && dacZero, "R1 zero forcing", adcZero, expAdc(2'b00));
    chk(adcInit == 1'b0, "R1 adcInit", adcInit, 0);

    frames(0, 4);
    frames(1, 1);            // release (R3)
    frames(1, 530);          // INIT then NORMAL (R4, R7)
    frames(0, 8);            // entry (R2)
    frames(1, 100);          // release into INIT
    frames(0, 8);            // abort during INIT (R8)
    frames(1, 530);          // fresh INIT window (R8)
    frames(0, 2);            // short drop, cancelled entry (R2)
    frames(1, 12);
    frames(0, 8);

    // R10: frame clock stopped, bit written to 1 while in reset
    @(negedge clk) runBit = 1'b1;
    repeat (300) @(negedge clk);
    chk(seqState == 2'b00, "R10 state frozen", seqState, 0);
    chk(zeroFlag == NUM_FLAGS'(expFlags(1)), "R10 flags frozen", zeroFlag, expFlags(1));
    frames(1, 12);

    for (int s = 0; s < 60; s++) begin
      bit lvl;
      int len;
      lvl = ($urandom % 3) != 0;
      len = 1 + ($urandom % 12);
      frames(lvl, len);
    end
    frames(1, 540);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule